// File: doc/BRIEF.md
# Software-Managed TLB with Probe

This block is a small fully associative translation buffer whose contents are maintained entirely by software. Each slot holds a virtual page number, an 8-bit address space identifier, a global flag and a field of page attributes. Software talks to it through two registers: a slot-number register (Index) and a page-tag register (EntryHi). It issues one of three operations: search, read of a numbered slot, or write of a numbered slot.

A search compares the tag in EntryHi with every slot in parallel. It then puts either the number of the lowest matching slot or a miss flag into Index. A read copies a slot back into EntryHi and onto the attribute outputs. A write fills a slot from EntryHi together with the supplied global flag and attributes.

Operations use a simple valid/ready handshake. Each one takes one cycle after acceptance and ends with a one-cycle done pulse. A free-running down-counter gives a replacement slot hint.

Top module: `tlb_probe_unit`

## Requirements
- R1: A slot matches a search when its page number equals EntryHi bits 31:13 and either its global flag is set or its identifier equals EntryHi bits 7:0.
- R2: On a search hit, Index becomes the number of the lowest-numbered matching slot, with bit 31 and all other upper bits cleared.
- R3: On a search miss, Index bit 31 is set and every other Index bit keeps its value.
- R4: A software write to EntryHi stores data bits 31:13 (page number) and 7:0 (current identifier) and clears bits 12:8.
- R5: A software write to Index keeps the old bit 31, stores the data ANDed with (slot count − 1) in the low bits and clears the rest. Slot reads and writes pick the slot given by those low bits, so larger values wrap.
- R6: An indexed write stores EntryHi's page number and identifier, `wr_global` and `wr_attr` into the selected slot.
- R7: An indexed read loads EntryHi with the slot's page number in bits 31:13 and its identifier in bits 7:0 (bits 12:8 zero). It also drives the slot's global flag and attributes on `rd_global` and `rd_attr`.
- R8: During and right after reset, Index and EntryHi are zero, every slot is all-zero and the replacement counter holds slot count − 1.
- R9: The replacement counter decrements by one every cycle and wraps from 0 to slot count − 1.
- R10: `op_code` encodes 0 search, 1 read, 2 write, 3 no-op. An operation is accepted on a clock edge where `op_valid` and `op_ready` are high. `op_ready` is then low for one cycle, and `op_done` pulses high for one cycle, two edges after acceptance. A request held while not ready waits.
- R11: When a search completes in the same cycle as a software Index write, the search result wins. When a read completes in the same cycle as a software EntryHi write, the read data wins. A software Index write coinciding with a read or write completion is kept.
- R12: An operation uses the Index and EntryHi values held at its acceptance edge. A software write in that same cycle does not affect it.
- R13: A no-op leaves Index, EntryHi and all slots unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 2 | 0 search, 1 read, 2 write, 3 no-op |
| op_ready | output | 1 | High when a request can be accepted |
| op_done | output | 1 | One-cycle completion pulse |
| idx_wr_en | input | 1 | Software write to Index |
| idx_wr_data | input | 32 | Data for Index write |
| ehi_wr_en | input | 1 | Software write to EntryHi |
| ehi_wr_data | input | 32 | Data for EntryHi write |
| wr_global | input | 1 | Global flag for a slot write |
| wr_attr | input | ATTR_W | Attributes for a slot write |
| index_o | output | 32 | Index register |
| entryhi_o | output | 32 | EntryHi register |
| random_o | output | log2(N_ENTRIES) | Replacement counter |
| rd_global | output | 1 | Global flag from the last read |
| rd_attr | output | ATTR_W | Attributes from the last read |

## Verification
A search result and a software Index write can land on the same edge, and so can a read writeback and a software EntryHi write. The bench provokes each pair by raising the software write enable in the cycle between acceptance and completion. It then checks that the register holds the search position or the read-back tag, not the software data. It also checks the mirror case, a software Index write during a read, where the software value must survive. A separate test writes EntryHi in the acceptance cycle itself and checks that the search used the older tag.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  localparam int VPN_W   = 19;
  localparam int VPN_LSB = 13;
  localparam int ASID_W  = 8;
  localparam logic [31:0] EHI_KEEP = 32'hFFFF_E0FF;
  localparam logic [31:0] MISS_BIT = 32'h8000_0000;

  typedef enum logic [1:0] {
    OP_PROBE = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_NOP   = 2'd3
  } tlb_op_e;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              g;
  } tlb_tag_t;

  function automatic logic [31:0] ehi_pack(logic [VPN_W-1:0] vpn, logic [ASID_W-1:0] asid);
    return {vpn, 5'b0, asid};
  endfunction

  function automatic logic [31:0] ehi_clean(logic [31:0] d);
    return d & EHI_KEEP;
  endfunction

  function automatic logic tag_match(tlb_tag_t e, logic [VPN_W-1:0] vpn, logic [ASID_W-1:0] asid);
    return (e.vpn == vpn) && (e.g || (e.asid == asid));
  endfunction

  function automatic logic [31:0] idx_sw_merge(logic [31:0] old, logic [31:0] data, logic [31:0] mask);
    return (old & MISS_BIT) | (data & mask);
  endfunction
endpackage

// File: rtl/tlb_entry_array.sv
`timescale 1ns/1ps
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int ATTR_W    = 6,
  localparam int IW = $clog2(N_ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_sel,
  input  tlb_tag_t            wr_tag,
  input  logic [ATTR_W-1:0]   wr_attr,
  input  logic [IW-1:0]       rd_sel,
  output tlb_tag_t            rd_tag,
  output logic [ATTR_W-1:0]   rd_attr,
  input  logic [VPN_W-1:0]    look_vpn,
  input  logic [ASID_W-1:0]   look_asid,
  output logic [N_ENTRIES-1:0] match_vec
);
  tlb_tag_t          tag_q  [N_ENTRIES];
  logic [ATTR_W-1:0] attr_q [N_ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N_ENTRIES; e++) begin
        tag_q[e]  <= '0;
        attr_q[e] <= '0;
      end
    end else if (wr_en) begin
      tag_q[wr_sel]  <= wr_tag;
      attr_q[wr_sel] <= wr_attr;
    end
  end

  assign rd_tag  = tag_q[rd_sel];
  assign rd_attr = attr_q[rd_sel];

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
    assign match_vec[e] = tag_match(tag_q[e], look_vpn, look_asid);
  end
endmodule

// File: rtl/tlb_first_hit.sv
`timescale 1ns/1ps
module tlb_first_hit #(
  parameter int N_ENTRIES = 16,
  localparam int IW = $clog2(N_ENTRIES)
) (
  input  logic [N_ENTRIES-1:0] match_vec,
  output logic                 hit,
  output logic [IW-1:0]        hit_pos
);
  always_comb begin
    hit     = |match_vec;
    hit_pos = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_pos = IW'(i);
    end
  end
endmodule

// File: rtl/tlb_ctrl.sv
`timescale 1ns/1ps
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int ATTR_W    = 6,
  localparam int IW = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  input  logic              idx_wr_en,
  input  logic [31:0]       idx_wr_data,
  input  logic              ehi_wr_en,
  input  logic [31:0]       ehi_wr_data,
  input  logic              wr_global,
  input  logic [ATTR_W-1:0] wr_attr,
  input  logic              hit,
  input  logic [IW-1:0]     hit_pos,
  input  tlb_tag_t          rd_tag,
  input  logic [ATTR_W-1:0] rd_attr_in,
  output logic              op_ready,
  output logic              op_done,
  output logic [31:0]       index_o,
  output logic [31:0]       entryhi_o,
  output logic [IW-1:0]     random_o,
  output logic              rd_global,
  output logic [ATTR_W-1:0] rd_attr,
  output logic [IW-1:0]     sel_o,
  output tlb_tag_t          op_tag,
  output logic [ATTR_W-1:0] op_attr,
  output logic              ev_accept,
  output logic              ev_probe_exec,
  output logic              ev_read_exec,
  output logic              ev_write_exec
);
  localparam logic [31:0] SEL_MASK = 32'(N_ENTRIES - 1);
  localparam logic [IW-1:0] RND_TOP = IW'(N_ENTRIES - 1);

  logic    busy_q;
  tlb_op_e op_q;

  assign op_ready      = !busy_q;
  assign ev_accept     = op_valid && !busy_q;
  assign ev_probe_exec = busy_q && (op_q == OP_PROBE);
  assign ev_read_exec  = busy_q && (op_q == OP_READ);
  assign ev_write_exec = busy_q && (op_q == OP_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      op_q      <= OP_NOP;
      sel_o     <= '0;
      op_tag    <= '0;
      op_attr   <= '0;
      op_done   <= 1'b0;
      index_o   <= '0;
      entryhi_o <= '0;
      random_o  <= RND_TOP;
      rd_global <= 1'b0;
      rd_attr   <= '0;
    end else begin
      op_done  <= busy_q;
      random_o <= (random_o == '0) ? RND_TOP : random_o - 1'b1;

      if (ev_accept) begin
        busy_q     <= 1'b1;
        op_q       <= tlb_op_e'(op_code);
        sel_o      <= index_o[IW-1:0];
        op_tag.vpn <= entryhi_o[31:VPN_LSB];
        op_tag.asid <= entryhi_o[ASID_W-1:0];
        op_tag.g   <= wr_global;
        op_attr    <= wr_attr;
      end else begin
        busy_q <= 1'b0;
      end

      if (ev_probe_exec) begin
        index_o <= hit ? 32'(hit_pos) : (index_o | MISS_BIT);
      end else if (idx_wr_en) begin
        index_o <= idx_sw_merge(index_o, idx_wr_data, SEL_MASK);
      end

      if (ev_read_exec) begin
        entryhi_o <= ehi_pack(rd_tag.vpn, rd_tag.asid);
        rd_global <= rd_tag.g;
        rd_attr   <= rd_attr_in;
      end else if (ehi_wr_en) begin
        entryhi_o <= ehi_clean(ehi_wr_data);
      end
    end
  end
endmodule

// File: rtl/tlb_probe_unit.sv
`timescale 1ns/1ps
module tlb_probe_unit
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int ATTR_W    = 6,
  localparam int IW = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  output logic              op_ready,
  output logic              op_done,
  input  logic              idx_wr_en,
  input  logic [31:0]       idx_wr_data,
  input  logic              ehi_wr_en,
  input  logic [31:0]       ehi_wr_data,
  input  logic              wr_global,
  input  logic [ATTR_W-1:0] wr_attr,
  output logic [31:0]       index_o,
  output logic [31:0]       entryhi_o,
  output logic [IW-1:0]     random_o,
  output logic              rd_global,
  output logic [ATTR_W-1:0] rd_attr
);
  tlb_tag_t              rd_tag;
  tlb_tag_t              op_tag;
  logic [ATTR_W-1:0]     arr_rd_attr;
  logic [ATTR_W-1:0]     op_attr;
  logic [IW-1:0]         sel;
  logic [N_ENTRIES-1:0]  match_vec;
  logic                  hit;
  logic [IW-1:0]         hit_pos;

  logic ev_accept, ev_probe_exec, ev_read_exec, ev_write_exec;
  logic ev_probe_hit, ev_probe_miss;

  assign ev_probe_hit  = ev_probe_exec && hit;
  assign ev_probe_miss = ev_probe_exec && !hit;

  tlb_entry_array #(.N_ENTRIES(N_ENTRIES), .ATTR_W(ATTR_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ev_write_exec),
    .wr_sel    (sel),
    .wr_tag    (op_tag),
    .wr_attr   (op_attr),
    .rd_sel    (sel),
    .rd_tag    (rd_tag),
    .rd_attr   (arr_rd_attr),
    .look_vpn  (op_tag.vpn),
    .look_asid (op_tag.asid),
    .match_vec (match_vec)
  );

  tlb_first_hit #(.N_ENTRIES(N_ENTRIES)) u_first (
    .match_vec (match_vec),
    .hit       (hit),
    .hit_pos   (hit_pos)
  );

  tlb_ctrl #(.N_ENTRIES(N_ENTRIES), .ATTR_W(ATTR_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_valid      (op_valid),
    .op_code       (op_code),
    .idx_wr_en     (idx_wr_en),
    .idx_wr_data   (idx_wr_data),
    .ehi_wr_en     (ehi_wr_en),
    .ehi_wr_data   (ehi_wr_data),
    .wr_global     (wr_global),
    .wr_attr       (wr_attr),
    .hit           (hit),
    .hit_pos       (hit_pos),
    .rd_tag        (rd_tag),
    .rd_attr_in    (arr_rd_attr),
    .op_ready      (op_ready),
    .op_done       (op_done),
    .index_o       (index_o),
    .entryhi_o     (entryhi_o),
    .random_o      (random_o),
    .rd_global     (rd_global),
    .rd_attr       (rd_attr),
    .sel_o         (sel),
    .op_tag        (op_tag),
    .op_attr       (op_attr),
    .ev_accept     (ev_accept),
    .ev_probe_exec (ev_probe_exec),
    .ev_read_exec  (ev_read_exec),
    .ev_write_exec (ev_write_exec)
  );
endmodule

// File: rtl/tlb_probe_unit_chk.sv
`timescale 1ns/1ps
module tlb_probe_unit_chk #(
  parameter int N_ENTRIES = 16,
  localparam int IW = $clog2(N_ENTRIES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_accept,
  input logic          ev_probe_exec,
  input logic          ev_probe_hit,
  input logic          ev_read_exec,
  input logic [IW-1:0] hit_pos,
  input logic          op_ready,
  input logic          op_done,
  input logic          idx_wr_en,
  input logic [31:0]   idx_wr_data,
  input logic          ehi_wr_en,
  input logic [31:0]   ehi_wr_data,
  input logic [31:0]   index_o,
  input logic [31:0]   entryhi_o,
  input logic [IW-1:0] random_o
);
  localparam logic [30:0] LOW_MASK = 31'(N_ENTRIES - 1);

  p_hit_position_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_probe_hit |=> (index_o == 32'($past(hit_pos))));

  p_miss_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_probe_exec && !ev_probe_hit) |=> (index_o[31] && index_o[30:0] == $past(index_o[30:0])));

  p_ehi_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ehi_wr_en && !ev_read_exec) |=> (entryhi_o[12:8] == 5'd0 &&
      entryhi_o[31:13] == $past(ehi_wr_data[31:13]) && entryhi_o[7:0] == $past(ehi_wr_data[7:0])));

  p_index_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr_en && !ev_probe_exec) |=> (index_o[31] == $past(index_o[31]) &&
      index_o[30:0] == ($past(idx_wr_data[30:0]) & LOW_MASK)));

  p_random_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (random_o == '0) |=> (random_o == IW'(N_ENTRIES - 1)));

  p_random_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (random_o != '0) |=> (random_o == $past(random_o) - 1'b1));

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (!op_ready && !ev_accept));

  p_done_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> ##2 op_done);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);
endmodule

bind tlb_probe_unit tlb_probe_unit_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ev_accept     (ev_accept),
  .ev_probe_exec (ev_probe_exec),
  .ev_probe_hit  (ev_probe_hit),
  .ev_read_exec  (ev_read_exec),
  .hit_pos       (hit_pos),
  .op_ready      (op_ready),
  .op_done       (op_done),
  .idx_wr_en     (idx_wr_en),
  .idx_wr_data   (idx_wr_data),
  .ehi_wr_en     (ehi_wr_en),
  .ehi_wr_data   (ehi_wr_data),
  .index_o       (index_o),
  .entryhi_o     (entryhi_o),
  .random_o      (random_o)
);

// File: tb/test_tlb_probe_unit.sv
`timescale 1ns/1ps
module test_tlb_probe_unit;
  localparam int N  = 16;
  localparam int AW = 6;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [1:0]    op_code = 2'd3;
  logic          op_ready, op_done;
  logic          idx_wr_en = 1'b0;
  logic [31:0]   idx_wr_data = '0;
  logic          ehi_wr_en = 1'b0;
  logic [31:0]   ehi_wr_data = '0;
  logic          wr_global = 1'b0;
  logic [AW-1:0] wr_attr = '0;
  logic [31:0]   index_o, entryhi_o;
  logic [IW-1:0] random_o;
  logic          rd_global;
  logic [AW-1:0] rd_attr;

  always #2.5 clk = ~clk;

  tlb_probe_unit #(.N_ENTRIES(N), .ATTR_W(AW)) i_tlb_probe_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_ready(op_ready), .op_done(op_done), .idx_wr_en(idx_wr_en),
    .idx_wr_data(idx_wr_data), .ehi_wr_en(ehi_wr_en), .ehi_wr_data(ehi_wr_data),
    .wr_global(wr_global), .wr_attr(wr_attr), .index_o(index_o),
    .entryhi_o(entryhi_o), .random_o(random_o), .rd_global(rd_global),
    .rd_attr(rd_attr)
  );

  int total = 0;
  int bad = 0;
  logic [18:0]   m_vpn [N];
  logic [7:0]    m_asid[N];
  logic          m_g   [N];
  logic [AW-1:0] m_attr[N];
  logic [31:0]   m_index = '0;
  logic [31:0]   m_ehi = '0;
  logic          m_rg = 1'b0;
  logic [AW-1:0] m_ra = '0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(logic [18:0] v, logic [7:0] a);
    return {v, 5'b0, a};
  endfunction

  function automatic logic [18:0] vpn_of(int i);
    return 19'(32'h100 + i * 37);
  endfunction

  function automatic int model_probe(logic [31:0] ehi);
    for (int i = 0; i < N; i++)
      if (m_vpn[i] == ehi[31:13] && (m_g[i] || m_asid[i] == ehi[7:0])) return i;
    return -1;
  endfunction

  task automatic model_exec(logic [1:0] code, logic [31:0] ehi, logic [31:0] idx, logic g, logic [AW-1:0] at);
    int r;
    int s;
    s = int'(idx[IW-1:0]);
    case (code)
      2'd0: begin
        r = model_probe(ehi);
        if (r >= 0) m_index = 32'(r); else m_index = m_index | 32'h8000_0000;
      end
      2'd1: begin
        m_ehi = pack(m_vpn[s], m_asid[s]); m_rg = m_g[s]; m_ra = m_attr[s];
      end
      2'd2: begin
        m_vpn[s] = ehi[31:13]; m_asid[s] = ehi[7:0]; m_g[s] = g; m_attr[s] = at;
      end
      default: ;
    endcase
  endtask

  task automatic set_ehi(logic [31:0] v);
    ehi_wr_en = 1'b1; ehi_wr_data = v;
    @(negedge clk);
    ehi_wr_en = 1'b0;
    m_ehi = v & 32'hFFFF_E0FF;
  endtask

  task automatic set_idx(logic [31:0] v);
    idx_wr_en = 1'b1; idx_wr_data = v;
    @(negedge clk);
    idx_wr_en = 1'b0;
    m_index = (m_index & 32'h8000_0000) | (v & 32'(N - 1));
  endtask

  task automatic op_run(logic [1:0] code, string req);
    op_valid = 1'b1; op_code = code;
    model_exec(code, m_ehi, m_index, wr_global, wr_attr);
    @(negedge clk);
    op_valid = 1'b0;
    check({req, " R10 busy"}, 32'(op_ready), 32'd0);
    @(negedge clk);
    check({req, " R10 done"}, 32'(op_done), 32'd1);
  endtask

  task automatic write_slot(int i, logic [18:0] v, logic [7:0] a, logic g, logic [AW-1:0] at);
    set_idx(32'(i));
    set_ehi(pack(v, a));
    wr_global = g; wr_attr = at;
    op_run(2'd2, "R6 write");
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [IW-1:0] prev;
    logic [31:0] snap_i, snap_e;
    for (int i = 0; i < N; i++) begin
      m_vpn[i] = '0; m_asid[i] = '0; m_g[i] = 1'b0; m_attr[i] = '0;
    end
    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8 index", index_o, 32'd0);
    check("R8 entryhi", entryhi_o, 32'd0);
    check("R8 random", 32'(random_o), 32'(N - 1));
    check("R8 ready", 32'(op_ready), 32'd1);
    check("R8 done", 32'(op_done), 32'd0);
    rst_n = 1'b1;
    // R9: counter sweep across several wraps
    prev = IW'(N - 1);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      prev = (prev == 0) ? IW'(N - 1) : prev - 1'b1;
      check("R9 random", 32'(random_o), 32'(prev));
    end
    // R8: slots start all-zero
    set_idx(32'd5);
    op_run(2'd1, "R8 read");
    check("R8 slot tag", entryhi_o, 32'd0);
    check("R8 slot g", 32'(rd_global), 32'd0);
    check("R8 slot attr", 32'(rd_attr), 32'd0);
    // R6/R7: fill and read back every slot
    for (int i = 0; i < N; i++) write_slot(i, vpn_of(i), 8'(i), (i == 7), AW'(i + 3));
    for (int i = 0; i < N; i++) begin
      set_idx(32'(i));
      op_run(2'd1, "R7 read");
      check("R7 entryhi", entryhi_o, m_ehi);
      check("R7 global", 32'(rd_global), 32'(m_rg));
      check("R7 attr", 32'(rd_attr), 32'(m_ra));
    end
    // R1/R2/R3: hit with own identifier, then foreign identifier
    for (int i = 0; i < N; i++) begin
      set_ehi(pack(vpn_of(i), 8'(i)));
      op_run(2'd0, "R1 probe");
      check("R1 R2 hit index", index_o, m_index);
      set_ehi(pack(vpn_of(i), 8'hAA));
      op_run(2'd0, "R3 probe");
      check("R1 R3 foreign asid index", index_o, m_index);
    end
    // R4: EntryHi field mask
    set_ehi(32'hFFFF_FFFF);
    @(negedge clk);
    check("R4 entryhi mask", entryhi_o, 32'hFFFF_E0FF);
    // R2: duplicates, lowest wins
    write_slot(12, 19'h7ABCD, 8'h05, 1'b0, 6'h11);
    write_slot(9, 19'h7ABCD, 8'h05, 1'b0, 6'h12);
    set_ehi(pack(19'h7ABCD, 8'h05));
    op_run(2'd0, "R2 probe dup");
    check("R2 lowest of two", index_o, m_index);
    write_slot(2, 19'h7ABCD, 8'h33, 1'b1, 6'h13);
    set_ehi(pack(19'h7ABCD, 8'h05));
    op_run(2'd0, "R2 probe global");
    check("R2 lowest with global", index_o, m_index);
    // R5: index write keeps miss flag, wraps
    set_ehi(pack(19'h00001, 8'h77));
    op_run(2'd0, "R3 probe miss");
    check("R3 miss flag", index_o, m_index);
    set_idx(32'h7FFF_FFF3);
    @(negedge clk);
    check("R5 index wrap keeps flag", index_o, m_index);
    op_run(2'd1, "R5 read");
    check("R5 read wrapped slot", entryhi_o, m_ehi);
    set_idx(32'h0000_0025);
    @(negedge clk);
    check("R5 index wrap2", index_o, m_index);
    // R11: probe vs software Index write in completion cycle
    set_ehi(pack(vpn_of(6), 8'd6));
    op_valid = 1'b1; op_code = 2'd0;
    model_exec(2'd0, m_ehi, m_index, wr_global, wr_attr);
    @(negedge clk);
    op_valid = 1'b0; idx_wr_en = 1'b1; idx_wr_data = 32'h0000_000B;
    @(negedge clk);
    idx_wr_en = 1'b0;
    check("R11 probe beats index write", index_o, m_index);
    // R11: read vs software EntryHi write
    set_idx(32'd4);
    op_valid = 1'b1; op_code = 2'd1;
    model_exec(2'd1, m_ehi, m_index, wr_global, wr_attr);
    @(negedge clk);
    op_valid = 1'b0; ehi_wr_en = 1'b1; ehi_wr_data = pack(19'h01234, 8'h55);
    idx_wr_en = 1'b1; idx_wr_data = 32'd13;
    @(negedge clk);
    ehi_wr_en = 1'b0; idx_wr_en = 1'b0;
    m_index = (m_index & 32'h8000_0000) | 32'd13;
    check("R11 read beats entryhi write", entryhi_o, m_ehi);
    check("R11 index write kept during read", index_o, m_index);
    // R12: operands captured at acceptance
    set_ehi(pack(vpn_of(8), 8'd8));
    op_valid = 1'b1; op_code = 2'd0;
    ehi_wr_en = 1'b1; ehi_wr_data = pack(vpn_of(10), 8'd10);
    model_exec(2'd0, m_ehi, m_index, wr_global, wr_attr);
    @(negedge clk);
    op_valid = 1'b0; ehi_wr_en = 1'b0;
    m_ehi = pack(vpn_of(10), 8'd10);
    @(negedge clk);
    check("R12 probe used old tag", index_o, m_index);
    check("R12 entryhi took new value", entryhi_o, m_ehi);
    // R10/R13: held no-op requests
    snap_i = index_o; snap_e = entryhi_o;
    op_valid = 1'b1; op_code = 2'd3;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      check("R10 ready pattern", 32'(op_ready), 32'((k % 2) == 0));
      check("R10 done pattern", 32'(op_done), 32'((k % 2) == 0));
    end
    op_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R13 nop index", index_o, snap_i);
    check("R13 nop entryhi", entryhi_o, snap_e);
    for (int i = 0; i < N; i++) begin
      set_idx(32'(i));
      op_run(2'd1, "R13 read");
      check("R13 slots intact", entryhi_o, m_ehi);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule